// File: doc/BRIEF.md
# Integrity Tree Branch Walker

This block sequences the memory reads needed to re-verify one leaf of a balanced A-ary integrity tree. Every node has a numeric position: the root sits at position 0 and positions grow level by level toward the leaves, so a node's parent is found by subtracting one and shifting right by log2 of the arity. Each node occupies a slot of equal size in external memory, and its address is a fixed base plus its position times the node size.

Given a leaf index and a start strobe, the walker emits the addresses of the leaf's siblings. It then moves up one level at a time. At each level it first asks an on-chip trusted node cache whether the parent is already held. On a miss, it fetches the parent and then that parent's siblings. The walk ends at the first cached node, which serves as a local root, or when the parent would be the root itself. The root is held in an on-chip register and is never fetched. Hashing and comparison are done by a downstream engine that consumes the request stream. Each request is tagged with the tree level of the node it names.

Top module: `itree_branch_walker`

## Requirements
- R1: After reset, busy, req_valid, look_valid, done and done_by_cache are all low.
- R2: A start while idle selects leaf position FIRST_LEAF + leaf_idx, where FIRST_LEAF = (ARITY^DEPTH - 1)/(ARITY - 1). The first requests name the other members of the leaf's sibling group in ascending position order, with the leaf itself left out, each tagged with level DEPTH.
- R3: Every request address equals BASE_ADDR + position × NODE_BYTES.
- R4: After the siblings of a node at position p, the walker presents a cache lookup for position (p - 1) >> log2(ARITY) for exactly one cycle, provided that position is not 0.
- R5: On a lookup miss, the parent is requested with a level tag one below the current level. The parent's siblings then follow in ascending order, and the walk continues upward.
- R6: On a lookup hit, no further requests are issued. The walk ends with done and done_by_cache both high in the cycle after the hit.
- R7: When the parent would be position 0, all siblings at level 1 are requested. The root is neither requested nor looked up, and done rises with done_by_cache low.
- R8: A request with req_valid high and req_ready low keeps req_valid, req_addr and req_level unchanged in the next cycle. A request is consumed only in a cycle where both req_valid and req_ready are high.
- R9: Start and leaf_idx are ignored while busy is high, so the request stream of the walk in progress is unchanged.
- R10: done is a single-cycle pulse, and in the cycle after it busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk for leaf_idx (taken only while idle) |
| leaf_idx | input | LEAF_W | Index of the leaf block to verify |
| busy | output | 1 | A walk is in progress |
| req_valid | output | 1 | A node fetch request is presented |
| req_ready | input | 1 | Memory side accepts the request |
| req_addr | output | ADDR_W | Byte address of the requested node |
| req_level | output | LVL_W | Tree level of the requested node (leaves at DEPTH) |
| look_valid | output | 1 | Trusted cache lookup is presented |
| look_pos | output | POS_W | Node position being looked up |
| look_hit | input | 1 | Trusted cache holds look_pos (sampled while look_valid) |
| done | output | 1 | Walk finished (one-cycle pulse) |
| done_by_cache | output | 1 | With done: walk ended at a cached node rather than the root |

## Verification
The hardest case to reach from the ports is a memory stall that holds a request across several cycles in the same walk where the cache hits partway up the branch. Both the hold rule and the early stop then have to hold on one request stream. The bench drives req_ready from a free-running shift register. It programs the cache model to claim one chosen position on the branch, at level 2 or level 1, so the hit lands after stalls have already occurred. A start pulsed mid-walk with a different leaf index checks that a running walk cannot be redirected.

// File: rtl/itw_pkg.sv
package itw_pkg;

   typedef enum logic [2:0] {
      WS_IDLE,
      WS_SIB,
      WS_LOOK,
      WS_PAR,
      WS_DONE
   } walk_state_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/itw_node_math.sv
module itw_node_math #(
   parameter int unsigned ARITY = 4,
   parameter int unsigned POS_W = 8,
   localparam int unsigned LG_A = $clog2(ARITY)
) (
   input  logic [POS_W-1:0] pos,
   output logic [POS_W-1:0] parent,
   output logic [POS_W-1:0] grp_base,
   output logic [LG_A-1:0]  self_slot
);
   logic [POS_W-1:0] pm1;

   always_comb begin
      pm1       = pos - POS_W'(1);
      parent    = pm1 >> LG_A;
      grp_base  = (parent << LG_A) + POS_W'(1);
      self_slot = pm1[LG_A-1:0];
   end
endmodule

// File: rtl/itw_addr_gen.sv
module itw_addr_gen import itw_pkg::*; #(
   parameter int unsigned    POS_W      = 8,
   parameter int unsigned    ADDR_W     = 32,
   parameter int unsigned    NODE_BYTES = 64,
   parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
   input  logic [POS_W-1:0]  pos,
   output logic [ADDR_W-1:0] addr
);
   generate
      if (is_pow2(NODE_BYTES)) begin : g_shift
         localparam int unsigned SH = $clog2(NODE_BYTES);
         assign addr = BASE_ADDR + (ADDR_W'(pos) << SH);
      end else begin : g_mult
         assign addr = BASE_ADDR + ADDR_W'(pos) * ADDR_W'(NODE_BYTES);
      end
   endgenerate
endmodule

// File: rtl/itree_branch_walker.sv
module itree_branch_walker import itw_pkg::*; #(
   parameter int unsigned       ARITY      = 4,
   parameter int unsigned       DEPTH      = 3,
   parameter int unsigned       ADDR_W     = 32,
   parameter int unsigned       NODE_BYTES = 64,
   parameter logic [ADDR_W-1:0] BASE_ADDR  = 32'h1000_0000,
   localparam int unsigned LG_A       = $clog2(ARITY),
   localparam int unsigned LEAF_W     = LG_A * DEPTH,
   localparam int unsigned POS_W      = LG_A * DEPTH + 2,
   localparam int unsigned LVL_W      = $clog2(DEPTH + 1),
   localparam int unsigned FIRST_LEAF = ((1 << (LG_A * DEPTH)) - 1) / (ARITY - 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [LEAF_W-1:0] leaf_idx,
   output logic              busy,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [ADDR_W-1:0] req_addr,
   output logic [LVL_W-1:0]  req_level,
   output logic              look_valid,
   output logic [POS_W-1:0]  look_pos,
   input  logic              look_hit,
   output logic              done,
   output logic              done_by_cache
);

   // elaboration-time parameter checks
   generate
      if (!is_pow2(ARITY) || ARITY < 2) begin : g_bad_arity
         $error("ARITY must be a power of two and at least 2");
      end
      if (DEPTH < 1) begin : g_bad_depth
         $error("DEPTH must be at least 1");
      end
      if (POS_W > 30) begin : g_bad_size
         $error("tree too large for position arithmetic");
      end
   endgenerate

   walk_state_e      st;
   logic [POS_W-1:0] cur_pos;
   logic [LVL_W-1:0] cur_lvl;
   logic [LG_A-1:0]  slot;
   logic             hit_q;

   logic [POS_W-1:0] par_pos;
   logic [POS_W-1:0] grp_pos;
   logic [LG_A-1:0]  self_slot;
   logic [POS_W-1:0] sib_pos;
   logic [POS_W-1:0] req_pos;
   logic             sib_emit;
   logic             sib_step;
   logic             at_root;

   itw_node_math #(.ARITY(ARITY), .POS_W(POS_W)) u_math (
      .pos       (cur_pos),
      .parent    (par_pos),
      .grp_base  (grp_pos),
      .self_slot (self_slot)
   );

   itw_addr_gen #(
      .POS_W      (POS_W),
      .ADDR_W     (ADDR_W),
      .NODE_BYTES (NODE_BYTES),
      .BASE_ADDR  (BASE_ADDR)
   ) u_addr (
      .pos  (req_pos),
      .addr (req_addr)
   );

   always_comb begin
      sib_pos       = grp_pos + POS_W'(slot);
      sib_emit      = (st == WS_SIB) && (slot != self_slot);
      sib_step      = (st == WS_SIB) && (!sib_emit || req_ready);
      at_root       = (par_pos == '0);
      req_valid     = sib_emit || (st == WS_PAR);
      req_pos       = (st == WS_PAR) ? par_pos : sib_pos;
      req_level     = (st == WS_PAR) ? (cur_lvl - LVL_W'(1)) : cur_lvl;
      look_valid    = (st == WS_LOOK) && !at_root;
      look_pos      = par_pos;
      busy          = (st != WS_IDLE);
      done          = (st == WS_DONE);
      done_by_cache = (st == WS_DONE) && hit_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= WS_IDLE;
         cur_pos <= '0;
         cur_lvl <= '0;
         slot    <= '0;
         hit_q   <= 1'b0;
      end else begin
         case (st)
            WS_IDLE: begin
               if (start) begin
                  cur_pos <= POS_W'(FIRST_LEAF) + POS_W'(leaf_idx);
                  cur_lvl <= LVL_W'(DEPTH);
                  slot    <= '0;
                  hit_q   <= 1'b0;
                  st      <= WS_SIB;
               end
            end
            WS_SIB: begin
               if (sib_step) begin
                  if (&slot) st <= WS_LOOK;
                  else       slot <= slot + LG_A'(1);
               end
            end
            WS_LOOK: begin
               if (at_root) begin
                  hit_q <= 1'b0;
                  st    <= WS_DONE;
               end else if (look_hit) begin
                  hit_q <= 1'b1;
                  st    <= WS_DONE;
               end else begin
                  st <= WS_PAR;
               end
            end
            WS_PAR: begin
               if (req_ready) begin
                  cur_pos <= par_pos;
                  cur_lvl <= cur_lvl - LVL_W'(1);
                  slot    <= '0;
                  st      <= WS_SIB;
               end
            end
            WS_DONE: st <= WS_IDLE;
            default: st <= WS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/itree_branch_walker_chk.sv
module itree_branch_walker_chk #(
   parameter int unsigned       ADDR_W    = 32,
   parameter int unsigned       LVL_W     = 2,
   parameter int unsigned       DEPTH     = 3,
   parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ADDR_W-1:0] req_addr,
   input logic [LVL_W-1:0]  req_level,
   input logic              look_valid,
   input logic              look_hit,
   input logic              done,
   input logic              done_by_cache
);

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!req_valid && !look_valid && !done));

   p_level_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_level != '0) && (int'(req_level) <= DEPTH));

   p_lookup_alone_r4: assert property (@(posedge clk) disable iff (!rst_n)
      look_valid |-> !req_valid);

   p_hit_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (look_valid && look_hit) |=> (done && done_by_cache));

   p_no_root_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_addr != BASE_ADDR));

   p_hold_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_level)));

   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

endmodule

bind itree_branch_walker itree_branch_walker_chk #(
   .ADDR_W    (ADDR_W),
   .LVL_W     (LVL_W),
   .DEPTH     (DEPTH),
   .BASE_ADDR (BASE_ADDR)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .busy          (busy),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .req_addr      (req_addr),
   .req_level     (req_level),
   .look_valid    (look_valid),
   .look_hit      (look_hit),
   .done          (done),
   .done_by_cache (done_by_cache)
);

// File: tb/itree_branch_walker_test.sv
`timescale 1ns/1ps
module itree_branch_walker_test;
   localparam int unsigned ARITY      = 4;
   localparam int unsigned DEPTH      = 3;
   localparam int unsigned ADDR_W     = 32;
   localparam int unsigned NODE_BYTES = 64;
   localparam logic [31:0] BASE       = 32'h1000_0000;
   localparam int unsigned LEAF_W     = 6;
   localparam int unsigned POS_W      = 8;
   localparam int unsigned LVL_W      = 2;
   localparam int          FIRST_LEAF = 21;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [LEAF_W-1:0] leaf_idx = '0;
   logic              busy;
   logic              req_valid;
   logic              req_ready = 1'b1;
   logic [ADDR_W-1:0] req_addr;
   logic [LVL_W-1:0]  req_level;
   logic              look_valid;
   logic [POS_W-1:0]  look_pos;
   logic              look_hit = 1'b0;
   logic              done;
   logic              done_by_cache;

   itree_branch_walker #(
      .ARITY(ARITY), .DEPTH(DEPTH), .ADDR_W(ADDR_W),
      .NODE_BYTES(NODE_BYTES), .BASE_ADDR(BASE)
   ) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .leaf_idx(leaf_idx),
      .busy(busy), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_level(req_level), .look_valid(look_valid),
      .look_pos(look_pos), .look_hit(look_hit), .done(done),
      .done_by_cache(done_by_cache)
   );

   always #10 clk = ~clk;

   int          n_chk = 0;
   int          n_bad = 0;
   logic [31:0] q_addr[$];
   int          q_lvl[$];
   int          q_look[$];
   bit          exp_cache;
   bit          got_done;
   int          hit_pos = 0;
   bit          rdy_rand = 1'b0;
   logic [7:0]  lfsr = 8'hA5;
   bit          prev_stall = 1'b0;
   logic [31:0] prev_addr;
   int          prev_lvl;

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] node_addr(input int p);
      return BASE + 32'(p) * NODE_BYTES;
   endfunction

   // expected branch model
   task automatic build_expect(input int idx, input int hit);
      int p;
      int lvl;
      int g;
      int par;
      p   = FIRST_LEAF + idx;
      lvl = DEPTH;
      while (1) begin
         g = ((p - 1) / ARITY) * ARITY + 1;
         for (int k = 0; k < ARITY; k++) begin
            if (g + k != p) begin
               q_addr.push_back(node_addr(g + k));
               q_lvl.push_back(lvl);
            end
         end
         par = (p - 1) / ARITY;
         if (par == 0) begin exp_cache = 1'b0; break; end
         q_look.push_back(par);
         if (par == hit) begin exp_cache = 1'b1; break; end
         q_addr.push_back(node_addr(par));
         q_lvl.push_back(lvl - 1);
         p   = par;
         lvl = lvl - 1;
      end
   endtask

   // input driver for the memory and cache sides
   always @(negedge clk) begin
      lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      req_ready <= rdy_rand ? (lfsr[0] | lfsr[3]) : 1'b1;
      look_hit  <= look_valid && (int'(look_pos) == hit_pos);
   end

   // monitor / scoreboard
   always @(negedge clk) begin
      #5;
      if (rst_n) begin
         if (prev_stall) begin
            check(req_valid && req_addr == prev_addr && int'(req_level) == prev_lvl,
                  "R8", "stalled request changed", req_addr, prev_addr);
         end
         prev_stall = req_valid && !req_ready;
         prev_addr  = req_addr;
         prev_lvl   = int'(req_level);
         if (req_valid && req_ready) begin
            if (q_addr.size() == 0) begin
               check(1'b0, "R6", "unexpected request", req_addr, 0);
            end else begin
               logic [31:0] ea;
               int          el;
               ea = q_addr.pop_front();
               el = q_lvl.pop_front();
               check(req_addr == ea, "R3", "request address", req_addr, ea);
               check(int'(req_level) == el, "R5", "request level", req_level, el);
            end
         end
         if (look_valid) begin
            if (q_look.size() == 0) begin
               check(1'b0, "R7", "unexpected lookup", look_pos, 0);
            end else begin
               int ep;
               ep = q_look.pop_front();
               check(int'(look_pos) == ep, "R4", "lookup position", look_pos, ep);
            end
         end
         if (done) begin
            if (exp_cache)
               check(done_by_cache == 1'b1, "R6", "done_by_cache", done_by_cache, 1);
            else
               check(done_by_cache == 1'b0, "R7", "done_by_cache", done_by_cache, 0);
            check(q_addr.size() == 0, "R6", "requests missing at done", q_addr.size(), 0);
            check(q_look.size() == 0, "R4", "lookups missing at done", q_look.size(), 0);
            got_done = 1'b1;
         end
      end
   end

   task automatic run_walk(input int idx, input int hit, input bit rnd, input bit intrude);
      int cyc;
      q_addr.delete();
      q_lvl.delete();
      q_look.delete();
      build_expect(idx, hit);
      hit_pos  = hit;
      rdy_rand = rnd;
      got_done = 1'b0;
      @(negedge clk);
      start    = 1'b1;
      leaf_idx = LEAF_W'(idx);
      @(negedge clk);
      start    = 1'b0;
      cyc      = 0;
      while (!got_done && cyc < 3000) begin
         @(negedge clk);
         cyc++;
         if (intrude && cyc == 3) begin
            start    = 1'b1;                       // R9: must be ignored
            leaf_idx = LEAF_W'(idx) ^ 6'h2A;
         end else begin
            start = 1'b0;
         end
      end
      start = 1'b0;
      if (!got_done) check(1'b0, "R10", "watchdog: walk never finished", cyc, 0);
      @(negedge clk);
      #5;
      check(!busy && !done, "R10", "busy/done after pulse", {busy, done}, 0);
      repeat (3) @(negedge clk);
      #5;
      check(!req_valid && !look_valid, "R9", "activity after walk", {req_valid, look_valid}, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #5;
      check(!busy && !req_valid && !look_valid && !done && !done_by_cache,
            "R1", "outputs in reset", {busy, req_valid, look_valid, done, done_by_cache}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #5;
      check(!busy && !req_valid && !done, "R1", "idle after reset", {busy, req_valid, done}, 0);

      run_walk(0, 0, 1'b0, 1'b0);   // R2 R7: first leaf, full branch to the root
      run_walk(63, 0, 1'b1, 1'b0);  // R8: last leaf with stalls
      run_walk(22, 10, 1'b0, 1'b0); // R6: hit at the first parent
      run_walk(37, 3, 1'b1, 1'b0);  // R6 R8: hit at level 1 with stalls
      run_walk(11, 0, 1'b1, 1'b1);  // R9: start during walk ignored
      run_walk(50, 17, 1'b1, 1'b0); // R5 R6: hit at level 2 with stalls
      run_walk(0, 2, 1'b0, 1'b0);   // R7: cached node off the branch never hits

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule